// File: doc/BRIEF.md
# Single-Line Burst Read Cache

This block sits between a CPU's word-read port and a memory controller that only delivers data in four-word bursts. It keeps exactly one cache line, the most recently fetched burst, together with one tag and one valid bit. A CPU read whose line-aligned address matches the tag is answered from the line on the next cycle. A read that misses starts one burst request. The four returned words are placed into the line in order, the line is marked valid, and the requested word is handed back.

Because the line is as wide as a burst, a stream of sequential reads waits on memory only once per four words. CPU writes that land in the held line patch the stored word under byte enables, so later reads see the new data. Writes that miss leave the line alone; the memory write itself is handled elsewhere. A flush input drops the line.

Top module: `burstLineCache`

## Requirements
- R1: After reset the line is invalid, and `cpuBusy`, `cpuRvalid` and `memReq` are low, so the first read always misses.
- R2: A read is accepted when `cpuReq` is high, `cpuWr` is low and `cpuBusy` is low. On a hit, `cpuRvalid` is high in the next cycle with `cpuRdata` equal to the stored word whose index is `cpuAddr[1:0]`.
- R3: On a read miss, `memReq` is high for exactly one cycle, starting the cycle after acceptance. `memLineAddr` then equals `cpuAddr` with bits [1:0] forced to zero, and `cpuBusy` is high from that cycle until the response.
- R4: During a refill, each cycle with `memValid` high stores `memData` into the next slot, in the order 0, 1, 2, 3. A `memValid` pulse while no refill is in progress changes nothing.
- R5: `cpuRvalid` goes high two cycles after the cycle in which the fourth burst word is sampled. It carries the word at the requested offset, and `cpuBusy` is low in that same cycle.
- R6: The line becomes valid only once all four burst words are stored. After a refill, reads of any word of that line hit.
- R7: After a miss, reads of the other three words of the same line hit and raise no `memReq`.
- R8: Requests presented while `cpuBusy` is high are not accepted. They raise no `memReq` and no `cpuRvalid`.
- R9: A write (`cpuReq` and `cpuWr` high, not busy) whose line address matches a valid line replaces only the bytes of the addressed word whose `cpuBe` bit is set. Bit b covers data bits [8b+7:8b]. A write never raises `cpuRvalid` or `memReq`, and a write that misses leaves the line unchanged.
- R10: `flush` invalidates the line from the next cycle. A read accepted in the same cycle as `flush` is treated as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate the held line |
| cpuReq | input | 1 | CPU request strobe |
| cpuWr | input | 1 | Request is a write when high |
| cpuAddr | input | ADDR_W | CPU word address |
| cpuBe | input | DATA_W/8 | Byte enables for writes |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data |
| cpuRvalid | output | 1 | Read data valid, one cycle |
| cpuBusy | output | 1 | Refill in progress, requests held off |
| memReq | output | 1 | One-cycle burst request |
| memLineAddr | output | ADDR_W | Line-aligned burst start address |
| memValid | input | 1 | Burst word strobe |
| memData | input | DATA_W | Burst word |

## Verification
A hit answers in the cycle after acceptance. A miss shows `memReq` and `cpuBusy` in the cycle after acceptance, and its response arrives two cycles after the fourth burst word. Writes, flushes and stray strobes take effect at the next edge and are observed through later reads. The bench drives every input on the falling edge and samples on the next falling edge, so each sample falls exactly in the cycle where its result is due. Random gaps between burst words, with random requests injected during the gaps, move the response cycle relative to the miss. The bench tracks this by counting the words it has delivered rather than waiting a fixed time.

// File: rtl/lineCachePkg.sv
package lineCachePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } cacheState_e;

  typedef struct packed {
    logic startFill;
    logic captureWord;
    logic finishFill;
    logic loadHit;
    logic loadPend;
    logic writeHit;
  } cacheStrobes_t;

endpackage

// File: rtl/lineCacheCtrl.sv
module lineCacheCtrl
  import lineCachePkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReq,
  input  logic          cpuWr,
  input  logic          lookupHit,
  input  logic          memValid,
  input  logic          fillLast,
  output cacheStrobes_t strb,
  output logic          memReq,
  output logic          cpuBusy,
  output logic          cpuRvalid
);

  cacheState_e state, stateNext;
  logic accept;

  assign accept  = cpuReq && (state == ST_IDLE);
  assign cpuBusy = (state != ST_IDLE);

  always_comb begin
    strb             = '0;
    strb.startFill   = accept && !cpuWr && !lookupHit;
    strb.loadHit     = accept && !cpuWr && lookupHit;
    strb.writeHit    = accept && cpuWr && lookupHit;
    strb.captureWord = (state == ST_FILL) && memValid;
    strb.finishFill  = strb.captureWord && fillLast;
    strb.loadPend    = (state == ST_DONE);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strb.startFill) stateNext = ST_FILL;
      ST_FILL: if (strb.finishFill) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      memReq    <= 1'b0;
      cpuRvalid <= 1'b0;
    end else begin
      state     <= stateNext;
      memReq    <= strb.startFill;
      cpuRvalid <= strb.loadHit || strb.loadPend;
    end
  end

  // R8: no response is ever delivered while a refill holds the port
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    cpuBusy |-> !cpuRvalid);

  // R3: burst request lasts a single cycle
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R3: the port is held off while the request is out
  p_miss_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> cpuBusy);

  // R2: an accepted hit answers on the next cycle
  p_hit_next_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuBusy && !cpuWr && lookupHit) |=> cpuRvalid);

  // R9: writes never produce a response or a burst
  p_write_silent_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuBusy && cpuWr) |=> (!cpuRvalid && !memReq));

endmodule

// File: rtl/lineCacheData.sv
module lineCacheData
  import lineCachePkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                flush,
  input  cacheStrobes_t       strb,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W/8-1:0] cpuBe,
  input  logic [DATA_W-1:0]   cpuWdata,
  input  logic                memValid,
  input  logic [DATA_W-1:0]   memData,
  output logic                lookupHit,
  output logic                fillLast,
  output logic [DATA_W-1:0]   cpuRdata,
  output logic [ADDR_W-1:0]   memLineAddr
);

  localparam int LINE_WORDS = 1 << OFS_W;
  localparam int TAG_W      = ADDR_W - OFS_W;
  localparam int BE_W       = DATA_W / 8;

  logic [DATA_W-1:0] lineWords [LINE_WORDS];
  logic [TAG_W-1:0]  tagReg;
  logic              validReg;
  logic [OFS_W-1:0]  pendOfs;
  logic [OFS_W-1:0]  fillCnt;
  logic [DATA_W-1:0] rdataReg;
  logic [OFS_W-1:0]  wordOfs;
  logic [TAG_W-1:0]  reqTag;
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] mergeWord;

  assign wordOfs     = cpuAddr[OFS_W-1:0];
  assign reqTag      = cpuAddr[ADDR_W-1:OFS_W];
  assign lookupHit   = validReg && (tagReg == reqTag) && !flush;
  assign fillLast    = memValid && (fillCnt == {OFS_W{1'b1}});
  assign memLineAddr = {tagReg, {OFS_W{1'b0}}};
  assign cpuRdata    = rdataReg;
  assign oldWord     = lineWords[wordOfs];

  for (genvar b = 0; b < BE_W; b++) begin : g_byteMerge
    assign mergeWord[b*8 +: 8] = cpuBe[b] ? cpuWdata[b*8 +: 8] : oldWord[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (strb.captureWord) lineWords[fillCnt] <= memData;
    else if (strb.writeHit) lineWords[wordOfs] <= mergeWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validReg <= 1'b0;
      tagReg   <= '0;
      pendOfs  <= '0;
      fillCnt  <= '0;
      rdataReg <= '0;
    end else begin
      if (flush)                validReg <= 1'b0;
      else if (strb.startFill)  validReg <= 1'b0;
      else if (strb.finishFill) validReg <= 1'b1;

      if (strb.startFill) begin
        tagReg  <= reqTag;
        pendOfs <= wordOfs;
        fillCnt <= '0;
      end else if (strb.captureWord) begin
        fillCnt <= fillCnt + 1'b1;
      end

      if (strb.loadHit)       rdataReg <= lineWords[wordOfs];
      else if (strb.loadPend) rdataReg <= lineWords[pendOfs];
    end
  end

  // R6: a completed burst makes the line valid
  p_valid_after_burst_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finishFill && !flush) |=> validReg);

  // R10: flush drops the line at the next edge
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !validReg);

  // R4: a refill always begins at slot zero with the line invalid
  p_fill_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.startFill |=> (fillCnt == '0 && !validReg));

  // R9: a write hit leaves the tag alone
  p_write_keeps_tag_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeHit |=> $stable(tagReg));

endmodule

// File: rtl/burstLineCache.sv
module burstLineCache
  import lineCachePkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int OFS_W  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                flush,
  input  logic                cpuReq,
  input  logic                cpuWr,
  input  logic [ADDR_W-1:0]   cpuAddr,
  input  logic [DATA_W/8-1:0] cpuBe,
  input  logic [DATA_W-1:0]   cpuWdata,
  output logic [DATA_W-1:0]   cpuRdata,
  output logic                cpuRvalid,
  output logic                cpuBusy,
  output logic                memReq,
  output logic [ADDR_W-1:0]   memLineAddr,
  input  logic                memValid,
  input  logic [DATA_W-1:0]   memData
);

  cacheStrobes_t strb;
  logic lookupHit;
  logic fillLast;

  lineCacheCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuReq    (cpuReq),
    .cpuWr     (cpuWr),
    .lookupHit (lookupHit),
    .memValid  (memValid),
    .fillLast  (fillLast),
    .strb      (strb),
    .memReq    (memReq),
    .cpuBusy   (cpuBusy),
    .cpuRvalid (cpuRvalid)
  );

  lineCacheData #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
  ) i_data (
    .clk         (clk),
    .rstN        (rstN),
    .flush       (flush),
    .strb        (strb),
    .cpuAddr     (cpuAddr),
    .cpuBe       (cpuBe),
    .cpuWdata    (cpuWdata),
    .memValid    (memValid),
    .memData     (memData),
    .lookupHit   (lookupHit),
    .fillLast    (fillLast),
    .cpuRdata    (cpuRdata),
    .memLineAddr (memLineAddr)
  );

endmodule

// File: tb/test_burstLineCache.sv
module test_burstLineCache;

  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int BE_W   = DATA_W / 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              flush = 1'b0;
  logic              cpuReq = 1'b0;
  logic              cpuWr = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [BE_W-1:0]   cpuBe = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic [DATA_W-1:0] cpuRdata;
  logic              cpuRvalid;
  logic              cpuBusy;
  logic              memReq;
  logic [ADDR_W-1:0] memLineAddr;
  logic              memValid = 1'b0;
  logic [DATA_W-1:0] memData = '0;

  int nChecks = 0;
  int nFail   = 0;

  logic              mValid = 1'b0;
  logic [ADDR_W-3:0] mTag = '0;
  logic [DATA_W-1:0] mLine [4];

  always #4 clk = ~clk;

  burstLineCache i_burstLineCache (
    .clk(clk), .rstN(rstN), .flush(flush), .cpuReq(cpuReq), .cpuWr(cpuWr),
    .cpuAddr(cpuAddr), .cpuBe(cpuBe), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuRvalid(cpuRvalid), .cpuBusy(cpuBusy), .memReq(memReq),
    .memLineAddr(memLineAddr), .memValid(memValid), .memData(memData)
  );

  function automatic logic [DATA_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    logic [31:0] h;
    h = ({10'd0, a} * 32'h9E37) ^ 32'h5A5A;
    return h[DATA_W-1:0] ^ h[31:16];
  endfunction

  function automatic logic [DATA_W-1:0] mergeBytes(input logic [DATA_W-1:0] oldW,
      input logic [DATA_W-1:0] newW, input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] r;
    r = oldW;
    for (int b = 0; b < BE_W; b++) if (be[b]) r[b*8 +: 8] = newW[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] addr, input bit withFlush);
    bit hitExp;
    logic [1:0] ofs;
    ofs = addr[1:0];
    hitExp = mValid && (mTag == addr[ADDR_W-1:2]) && !withFlush;
    @(negedge clk);
    cpuReq = 1'b1; cpuWr = 1'b0; cpuAddr = addr; flush = withFlush;
    @(negedge clk);
    cpuReq = 1'b0; flush = 1'b0;
    if (withFlush) mValid = 1'b0;
    if (hitExp) begin
      check("R2 hit rvalid", 32'(cpuRvalid), 32'd1);
      check("R2 hit data", 32'(cpuRdata), 32'(mLine[ofs]));
      check("R7 hit no memReq", 32'(memReq), 32'd0);
    end else begin
      check(withFlush ? "R10 flush-same-cycle miss" : "R3 memReq", 32'(memReq), 32'd1);
      check("R3 line address", 32'(memLineAddr), 32'({addr[ADDR_W-1:2], 2'b00}));
      check("R3 busy", 32'(cpuBusy), 32'd1);
      for (int i = 0; i < 4; i++) begin
        int gap;
        gap = int'($urandom % 3);
        for (int g = 0; g < gap; g++) begin
          cpuReq = ($urandom % 2) == 1;
          cpuWr = ($urandom % 2) == 1;
          cpuAddr = ADDR_W'($urandom);
          @(negedge clk);
          check("R8 held-off no memReq", 32'(memReq), 32'd0);
          check("R8 held-off no rvalid", 32'(cpuRvalid), 32'd0);
        end
        cpuReq = 1'b0; cpuWr = 1'b0;
        memValid = 1'b1;
        memData = memWord({addr[ADDR_W-1:2], 2'(i)});
        @(negedge clk);
        memValid = 1'b0;
        if (i < 3) check("R6 busy until burst done", 32'(cpuBusy), 32'd1);
      end
      @(negedge clk);
      mValid = 1'b1;
      mTag = addr[ADDR_W-1:2];
      for (int i = 0; i < 4; i++) mLine[i] = memWord({addr[ADDR_W-1:2], 2'(i)});
      check("R5 miss rvalid", 32'(cpuRvalid), 32'd1);
      check("R5 miss data", 32'(cpuRdata), 32'(mLine[ofs]));
      check("R5 busy released", 32'(cpuBusy), 32'd0);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] addr, input logic [BE_W-1:0] be,
                         input logic [DATA_W-1:0] data);
    @(negedge clk);
    cpuReq = 1'b1; cpuWr = 1'b1; cpuAddr = addr; cpuBe = be; cpuWdata = data;
    @(negedge clk);
    cpuReq = 1'b0; cpuWr = 1'b0;
    check("R9 write no rvalid", 32'(cpuRvalid), 32'd0);
    check("R9 write no memReq", 32'(memReq), 32'd0);
    if (mValid && mTag == addr[ADDR_W-1:2])
      mLine[addr[1:0]] = mergeBytes(mLine[addr[1:0]], data, be);
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    mValid = 1'b0;
  endtask

  task automatic strayValid();
    @(negedge clk);
    memValid = 1'b1; memData = 16'hDEAD;
    @(negedge clk);
    memValid = 1'b0;
    check("R4 stray strobe no rvalid", 32'(cpuRvalid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset busy", 32'(cpuBusy), 32'd0);
    check("R1 reset rvalid", 32'(cpuRvalid), 32'd0);
    check("R1 reset memReq", 32'(memReq), 32'd0);

    // R1/R7: first read misses, the rest of the line hits
    doRead(22'h000102, 1'b0);
    doRead(22'h000100, 1'b0);
    doRead(22'h000101, 1'b0);
    doRead(22'h000103, 1'b0);
    doRead(22'h000102, 1'b0);

    // R9: partial and full writes into the line, then a write miss
    doWrite(22'h000101, 2'b01, 16'hA5C3);
    doRead(22'h000101, 1'b0);
    doWrite(22'h000103, 2'b10, 16'h7E11);
    doWrite(22'h000100, 2'b11, 16'h1234);
    doWrite(22'h002000, 2'b11, 16'hFFFF);
    for (int i = 0; i < 4; i++) doRead(22'h000100 + 22'(i), 1'b0);

    // R4: stray strobe while idle leaves the line untouched
    strayValid();
    for (int i = 0; i < 4; i++) doRead(22'h000100 + 22'(i), 1'b0);

    // R10: flush then re-read misses; flush with read same cycle misses
    doFlush();
    doRead(22'h000102, 1'b0);
    doRead(22'h000103, 1'b0);
    doRead(22'h000103, 1'b1);
    doRead(22'h000101, 1'b0);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [ADDR_W-1:0] a;
      op = int'($urandom % 16);
      a = 22'h003000 + 22'($urandom % 32);
      if (op < 9) doRead(a, 1'b0);
      else if (op < 13) doWrite(a, BE_W'($urandom), DATA_W'($urandom));
      else if (op == 13) doFlush();
      else if (op == 14) strayValid();
      else doRead(a, 1'b1);
    end

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule